// File: doc/BRIEF.md
# Eight-bit ALU with status flag generation

This block is the arithmetic core of a classic 8-bit processor datapath. It holds no state and has no clock. An operation code selects one of eleven functions: byte add, subtract and compare, the three bitwise operations, byte increment and decrement, and a 16-bit register-pair add. From the operands and the incoming status byte, the block computes the result, a write strobe for the destination register, and the next status byte. The register that latches the status byte sits outside the block.

The status byte is reproduced bit for bit. This covers the two unnamed bits 3 and 5, which copy result bits. It also covers the half-carry and overflow rules that differ between operations. Increment, decrement and the pair add leave some incoming flags unchanged. Add-with-carry shares the adder with plain add through a carry-use strobe, and subtract-with-borrow shares the subtractor with plain subtract in the same way.

Top module: `alu_flag_unit`

## Requirements
- R1: The status byte uses these positions: bit 0 carry, bit 1 subtract, bit 2 parity/overflow, bit 4 half-carry, bit 6 zero, bit 7 sign. Bits 3 and 5 copy result bits 3 and 5. For byte operations, zero is set when the 8-bit result is 0 and sign equals result bit 7.
- R2: Add (code 0) and add-with-carry (code 1, which adds status bit 0) set carry from bit 8 of the 9-bit sum. Half-carry is the carry out of the low nibble, including the carry in. Overflow is set when both operands share a sign that differs from the result's sign. Subtract is cleared.
- R3: Subtract (code 2) and subtract-with-borrow (code 3, which also subtracts status bit 0) set the subtract flag and set carry from bit 8 of the 9-bit difference. Half-carry is set when the low nibble of A is below the low nibble of B plus the borrow. Overflow is set when the operand signs differ and the result sign differs from A.
- R4: Compare (code 4) produces the same status byte as subtract, with bits 3 and 5 taken from the difference. It holds the write strobe low and drives the result to zero.
- R5: AND (code 5), XOR (code 6) and OR (code 7) clear carry and subtract. They set bit 2 when the result has an even number of one bits. Half-carry is 1 for AND and 0 for XOR and OR.
- R6: Increment (code 8) adds one to A. It keeps the incoming carry and clears subtract. Half-carry is set when the new low nibble is 0, and overflow is set only for a result of 0x80.
- R7: Decrement (code 9) subtracts one from A. It keeps the incoming carry and sets subtract. Half-carry is set when the old low nibble was 0, and overflow is set only for a result of 0x7F.
- R8: Pair add (code 10) adds the full 16-bit operands. It keeps sign, zero and parity/overflow from the incoming byte and clears subtract. Half-carry is the carry out of bit 11 and carry is the carry out of bit 15. Bits 3 and 5 come from result bits 11 and 13.
- R9: Codes 11 to 15 hold the write strobe low, drive the result to zero, and pass the incoming status byte through unchanged.
- R10: Codes 0 to 3 and 5 to 10 raise the write strobe. Every byte operation reads only the low bytes of the operands and drives the result's upper byte to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| aIn | input | 16 | First operand; the low byte is the accumulator or register, and the full width is the pair |
| bIn | input | 16 | Second operand; the low byte for byte operations, the full width for the pair add |
| flagIn | input | 8 | Incoming status byte |
| opCode | input | 4 | Operation select, codes 0 to 10 |
| result | output | 16 | Operation result |
| resultWe | output | 1 | Destination write strobe |
| flagOut | output | 8 | Next status byte |

## Verification
The unit holds no state, so a bad strobe decode or a wrong flag term appears at the ports as soon as the inputs settle, on the same vector. A mis-decoded strobe corrupts every vector of the affected operation code. A wrong nibble or overflow term shows only on operand pairs that reach that boundary. For this reason, every byte operation is swept over all operand pairs with both carry-in values. The pair add is swept across the carry boundaries at bits 11 and 15.

// File: rtl/aluflag_pkg.sv
`timescale 1ns/1ps
package aluflag_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int OP_W   = 4;
  localparam int FLAG_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int MSB    = BYTE_W - 1;

  // status byte positions
  localparam int FC  = 0;
  localparam int FN  = 1;
  localparam int FPV = 2;
  localparam int FX3 = 3;
  localparam int FH  = 4;
  localparam int FX5 = 5;
  localparam int FZ  = 6;
  localparam int FS  = 7;

  // wide-add positions feeding the status byte
  localparam int WIDE_X3  = BYTE_W + FX3;
  localparam int WIDE_X5  = BYTE_W + FX5;
  localparam int WIDE_HC  = BYTE_W + NIB_W;
  localparam int WIDE_TOP = WORD_W;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_AND  = 4'd5,
    OP_XOR  = 4'd6,
    OP_OR   = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_ADDW = 4'd10
  } aluOp_e;

  typedef struct packed {
    logic valid;
    logic arith;
    logic subtract;
    logic carryUse;
    logic logicAnd;
    logic logicXor;
    logic logicOr;
    logic incOp;
    logic decOp;
    logic wide;
    logic writeEn;
  } aluStrobe_t;
endpackage

// File: rtl/alu_ctrl.sv
`timescale 1ns/1ps
module alu_ctrl
  import aluflag_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  output aluStrobe_t      strobe
);
  always_comb begin
    strobe = '0;
    case (opCode)
      OP_ADD:  begin strobe.valid = 1'b1; strobe.arith = 1'b1; strobe.writeEn = 1'b1; end
      OP_ADC:  begin strobe.valid = 1'b1; strobe.arith = 1'b1; strobe.carryUse = 1'b1; strobe.writeEn = 1'b1; end
      OP_SUB:  begin strobe.valid = 1'b1; strobe.arith = 1'b1; strobe.subtract = 1'b1; strobe.writeEn = 1'b1; end
      OP_SBC:  begin strobe.valid = 1'b1; strobe.arith = 1'b1; strobe.subtract = 1'b1; strobe.carryUse = 1'b1; strobe.writeEn = 1'b1; end
      OP_CMP:  begin strobe.valid = 1'b1; strobe.arith = 1'b1; strobe.subtract = 1'b1; end
      OP_AND:  begin strobe.valid = 1'b1; strobe.logicAnd = 1'b1; strobe.writeEn = 1'b1; end
      OP_XOR:  begin strobe.valid = 1'b1; strobe.logicXor = 1'b1; strobe.writeEn = 1'b1; end
      OP_OR:   begin strobe.valid = 1'b1; strobe.logicOr = 1'b1; strobe.writeEn = 1'b1; end
      OP_INC:  begin strobe.valid = 1'b1; strobe.incOp = 1'b1; strobe.writeEn = 1'b1; end
      OP_DEC:  begin strobe.valid = 1'b1; strobe.decOp = 1'b1; strobe.writeEn = 1'b1; end
      OP_ADDW: begin strobe.valid = 1'b1; strobe.wide = 1'b1; strobe.writeEn = 1'b1; end
      default: strobe = '0;
    endcase
  end

  // exactly one function class per valid code, none otherwise
  always_comb begin
    AST_ONE_CLASS: assert ($countones({strobe.arith, strobe.logicAnd, strobe.logicXor,
                                       strobe.logicOr, strobe.incOp, strobe.decOp,
                                       strobe.wide}) == (strobe.valid ? 1 : 0)); // R10
  end
endmodule

// File: rtl/alu_dp.sv
`timescale 1ns/1ps
module alu_dp
  import aluflag_pkg::*;
(
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] bIn,
  input  logic [FLAG_W-1:0] flagIn,
  input  aluStrobe_t        strobe,
  output logic [WORD_W-1:0] result,
  output logic [FLAG_W-1:0] flagOut
);
  localparam logic [BYTE_W-1:0] ONE_B   = BYTE_W'(1);
  localparam logic [BYTE_W-1:0] SIGN_B  = {1'b1, {MSB{1'b0}}};
  localparam logic [BYTE_W-1:0] MAXPOS  = ~SIGN_B;
  localparam logic [NIB_W-1:0]  NIB_Z   = '0;

  logic [BYTE_W-1:0] opA;
  logic [BYTE_W-1:0] opB;
  logic              carryIn;
  logic [BYTE_W:0]   sumExt;
  logic [BYTE_W:0]   difExt;
  logic [WORD_W:0]   wideSum;

  // byte-path outcome
  logic [BYTE_W-1:0] byteRes;
  logic              halfC;
  logic              parOv;
  logic              subFlag;
  logic              carryOut;

  always_comb begin
    opA     = aIn[BYTE_W-1:0];
    opB     = bIn[BYTE_W-1:0];
    carryIn = strobe.carryUse & flagIn[FC];
    sumExt  = {1'b0, opA} + {1'b0, opB} + {{BYTE_W{1'b0}}, carryIn};
    difExt  = {1'b0, opA} - {1'b0, opB} - {{BYTE_W{1'b0}}, carryIn};
    wideSum = {1'b0, aIn} + {1'b0, bIn};
  end

  // byte function select and per-class flag terms
  always_comb begin
    byteRes  = '0;
    halfC    = 1'b0;
    parOv    = 1'b0;
    subFlag  = 1'b0;
    carryOut = 1'b0;
    if (strobe.arith) begin
      subFlag = strobe.subtract;
      if (strobe.subtract) begin
        byteRes  = difExt[BYTE_W-1:0];
        carryOut = difExt[BYTE_W];
        halfC    = difExt[NIB_W] ^ opA[NIB_W] ^ opB[NIB_W];
        parOv    = (opA[MSB] ^ opB[MSB]) & (difExt[MSB] ^ opA[MSB]);
      end else begin
        byteRes  = sumExt[BYTE_W-1:0];
        carryOut = sumExt[BYTE_W];
        halfC    = sumExt[NIB_W] ^ opA[NIB_W] ^ opB[NIB_W];
        parOv    = ~(opA[MSB] ^ opB[MSB]) & (sumExt[MSB] ^ opA[MSB]);
      end
    end else if (strobe.logicAnd | strobe.logicXor | strobe.logicOr) begin
      if (strobe.logicAnd)      byteRes = opA & opB;
      else if (strobe.logicXor) byteRes = opA ^ opB;
      else                      byteRes = opA | opB;
      halfC = strobe.logicAnd;
      parOv = ~^byteRes;
    end else if (strobe.incOp) begin
      byteRes  = opA + ONE_B;
      carryOut = flagIn[FC];
      halfC    = (byteRes[NIB_W-1:0] == NIB_Z);
      parOv    = (byteRes == SIGN_B);
    end else if (strobe.decOp) begin
      byteRes  = opA - ONE_B;
      carryOut = flagIn[FC];
      subFlag  = 1'b1;
      halfC    = (opA[NIB_W-1:0] == NIB_Z);
      parOv    = (byteRes == MAXPOS);
    end
  end

  // status byte and result assembly
  always_comb begin
    if (!strobe.valid) begin
      flagOut = flagIn;
      result  = '0;
    end else if (strobe.wide) begin
      flagOut      = flagIn;
      flagOut[FN]  = 1'b0;
      flagOut[FC]  = wideSum[WIDE_TOP];
      flagOut[FH]  = wideSum[WIDE_HC] ^ aIn[WIDE_HC] ^ bIn[WIDE_HC];
      flagOut[FX3] = wideSum[WIDE_X3];
      flagOut[FX5] = wideSum[WIDE_X5];
      result       = wideSum[WORD_W-1:0];
    end else begin
      flagOut[FS]  = byteRes[MSB];
      flagOut[FZ]  = (byteRes == '0);
      flagOut[FX5] = byteRes[FX5];
      flagOut[FH]  = halfC;
      flagOut[FX3] = byteRes[FX3];
      flagOut[FPV] = parOv;
      flagOut[FN]  = subFlag;
      flagOut[FC]  = carryOut;
      result       = strobe.writeEn ? {{BYTE_W{1'b0}}, byteRes} : '0;
    end
  end
endmodule

// File: rtl/alu_flag_unit.sv
`timescale 1ns/1ps
module alu_flag_unit
  import aluflag_pkg::*;
(
  input  logic [WORD_W-1:0] aIn,
  input  logic [WORD_W-1:0] bIn,
  input  logic [FLAG_W-1:0] flagIn,
  input  logic [OP_W-1:0]   opCode,
  output logic [WORD_W-1:0] result,
  output logic              resultWe,
  output logic [FLAG_W-1:0] flagOut
);
  aluStrobe_t strobe;

  alu_ctrl u_ctrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  alu_dp u_dp (
    .aIn     (aIn),
    .bIn     (bIn),
    .flagIn  (flagIn),
    .strobe  (strobe),
    .result  (result),
    .flagOut (flagOut)
  );

  assign resultWe = strobe.writeEn;

  always_comb begin
    if (opCode <= OP_DEC) begin
      AST_ZERO_MATCH: assert (flagOut[FZ] == (result[BYTE_W-1:0] == '0) || opCode == OP_CMP); // R1
      AST_UPPER_CLEAR: assert (result[WORD_W-1:BYTE_W] == '0); // R10
    end
    if (opCode == OP_SUB || opCode == OP_SBC || opCode == OP_CMP || opCode == OP_DEC) begin
      AST_SUB_MARK: assert (flagOut[FN]); // R3
    end
    if (opCode == OP_CMP) begin
      AST_CMP_NOWRITE: assert (!resultWe && result == '0); // R4
    end
    if (opCode == OP_AND || opCode == OP_XOR || opCode == OP_OR) begin
      AST_LOGIC_CLEAR: assert (!flagOut[FC] && !flagOut[FN]); // R5
    end
    if (opCode == OP_INC || opCode == OP_DEC) begin
      AST_KEEP_CARRY: assert (flagOut[FC] == flagIn[FC]); // R6
    end
    if (opCode == OP_ADDW) begin
      AST_WIDE_KEEP: assert (flagOut[FS] == flagIn[FS] && flagOut[FZ] == flagIn[FZ]
                             && flagOut[FPV] == flagIn[FPV] && !flagOut[FN]); // R8
    end
    if (opCode > OP_ADDW) begin
      AST_UNUSED_HOLD: assert (flagOut == flagIn && !resultWe && result == '0); // R9
    end
  end
endmodule

// File: tb/sim_alu_flag_unit.sv
`timescale 1ns/1ps
module sim_alu_flag_unit;
  logic        clk = 1'b0;
  logic [15:0] aIn = '0;
  logic [15:0] bIn = '0;
  logic [7:0]  flagIn = '0;
  logic [3:0]  opCode = '0;
  logic [15:0] result;
  logic        resultWe;
  logic [7:0]  flagOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  alu_flag_unit u0 (
    .aIn(aIn), .bIn(bIn), .flagIn(flagIn), .opCode(opCode),
    .result(result), .resultWe(resultWe), .flagOut(flagOut)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run exceeded %0d cycles, actual hung expected done", cycles);
      finishRun();
    end
  end

  task automatic finishRun();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic int parBit(int v);
    int n = 0;
    for (int k = 0; k < 8; k++) n += (v >> k) & 1;
    return (n % 2 == 0) ? 4 : 0;
  endfunction

  // reference model: {we, result16, flags}
  function automatic logic [24:0] refCalc(int op, int a, int b, int f);
    int x = a & 255, y = b & 255, c = f & 1, cc, t, r, fl, we;
    we = 1; r = 0; fl = f;
    case (op)
      0, 1: begin
        cc = (op == 1) ? c : 0;
        t  = x + y + cc; r = t & 255;
        fl = (r & 'hA8) | (t >> 8) | ((((x & 15) + (y & 15) + cc) > 15) ? 16 : 0)
           | (((~(x ^ y)) & 'h80 & (t ^ x)) != 0 ? 4 : 0) | ((r == 0) ? 64 : 0);
      end
      2, 3, 4: begin
        cc = (op == 3) ? c : 0;
        t  = (x - y - cc) & 'h1FF; r = t & 255;
        fl = (r & 'hA8) | (t >> 8) | (((x & 15) < ((y & 15) + cc)) ? 16 : 0)
           | ((((x ^ y) & 'h80 & (t ^ x)) != 0) ? 4 : 0) | 2 | ((r == 0) ? 64 : 0);
        if (op == 4) begin we = 0; r = 0; end
      end
      5, 6, 7: begin
        r  = (op == 5) ? (x & y) : (op == 6) ? (x ^ y) : (x | y);
        fl = (r & 'hA8) | ((r == 0) ? 64 : 0) | parBit(r) | ((op == 5) ? 16 : 0);
      end
      8: begin
        r  = (x + 1) & 255;
        fl = c | (r & 'hA8) | (((r & 15) == 0) ? 16 : 0) | ((r == 0) ? 64 : 0) | ((r == 128) ? 4 : 0);
      end
      9: begin
        r  = (x - 1) & 255;
        fl = c | (((x & 15) == 0) ? 16 : 0) | 2 | (r & 'hA8) | ((r == 127) ? 4 : 0) | ((r == 0) ? 64 : 0);
      end
      10: begin
        t  = (a & 'hFFFF) + (b & 'hFFFF); r = t & 'hFFFF;
        fl = (f & 'hC4) | ((((a & 'hFFF) + (b & 'hFFF)) > 'hFFF) ? 16 : 0)
           | ((t >> 8) & 'h28) | ((t >> 16) & 1);
      end
      default: begin we = 0; r = 0; fl = f; end
    endcase
    return {we[0], r[15:0], fl[7:0]};
  endfunction

  // sweep state: first mismatch of the current sweep
  int   misCount;
  logic [24:0] firstAct, firstExp;
  int   firstA, firstB, firstF;

  task automatic applyOne(int op, int a, int b, int f);
    logic [24:0] exp, act;
    opCode = op[3:0]; aIn = a[15:0]; bIn = b[15:0]; flagIn = f[7:0];
    #1;
    exp = refCalc(op, a, b, f);
    act = {resultWe, result, flagOut};
    if (act !== exp) begin
      if (misCount == 0) begin
        firstAct = act; firstExp = exp; firstA = a; firstB = b; firstF = f;
      end
      misCount++;
    end
  endtask

  task automatic closeSweep(string tag, int op, int cin);
    checks++;
    if (misCount != 0) begin
      errors++;
      $display("FAIL %s op=%0d cin=%0d (%0d vectors) a=%h b=%h f=%h actual we/res/fl=%h expected %h",
               tag, op, cin, misCount, firstA[15:0], firstB[15:0], firstF[7:0], firstAct, firstExp);
    end
    misCount = 0;
  endtask

  task automatic sweepByte(string tag, int op, int cin);
    misCount = 0;
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        applyOne(op, a, b, ((a ^ b ^ 'h5A) & 'hFE) | cin);
    closeSweep(tag, op, cin);
  endtask

  task automatic directOne(string tag, int op, int a, int b, int f);
    misCount = 0;
    applyOne(op, a, b, f);
    closeSweep(tag, op, f & 1);
  endtask

  // R1: quiescent inputs and undocumented copy bits
  task automatic testLayout();
    directOne("R1", 0, 0, 0, 0);             // zero result -> Z set
    directOne("R1", 0, 'h20, 'h08, 0);       // result 0x28, bits 5 and 3 copied
    directOne("R1", 5, 'hFF, 'h80, 0);       // sign from bit 7
  endtask

  task automatic testAdd();   // R2
    for (int op = 0; op < 2; op++)
      for (int cin = 0; cin < 2; cin++) sweepByte("R2", op, cin);
  endtask

  task automatic testSub();   // R3
    for (int op = 2; op < 4; op++)
      for (int cin = 0; cin < 2; cin++) sweepByte("R3", op, cin);
  endtask

  task automatic testCompare(); // R4
    for (int cin = 0; cin < 2; cin++) sweepByte("R4", 4, cin);
  endtask

  task automatic testLogic(); // R5
    for (int op = 5; op < 8; op++)
      for (int cin = 0; cin < 2; cin++) sweepByte("R5", op, cin);
  endtask

  task automatic testStep(string tag, int op); // R6 / R7
    for (int cin = 0; cin < 2; cin++) begin
      misCount = 0;
      for (int a = 0; a < 256; a++)
        for (int f = 0; f < 256; f += 37)
          applyOne(op, a | ((f & 'hF) << 8), (a * 7 + f) & 'hFFFF, (f & 'hFE) | cin);
      closeSweep(tag, op, cin);
    end
  endtask

  task automatic testWide(); // R8
    misCount = 0;
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 64; j++)
        applyOne(10, (i * 257 + j * 13) & 'hFFFF, (j * 1031 + i * 3) & 'hFFFF, (i ^ j) & 'hFF);
    applyOne(10, 'hFFFF, 1, 'hFF);
    applyOne(10, 'h0FFF, 1, 0);
    applyOne(10, 'h7FFF, 1, 'h44);
    applyOne(10, 'h2800, 0, 0);
    closeSweep("R8", 10, 0);
  endtask

  task automatic testUnused(); // R9
    for (int op = 11; op < 16; op++) begin
      misCount = 0;
      applyOne(op, 'h1234, 'hABCD, 'hA5);
      applyOne(op, 'hFFFF, 'hFFFF, 'h5A);
      applyOne(op, 0, 0, 'hFF);
      closeSweep("R9", op, 0);
    end
  endtask

  // R10: write strobe per code and upper byte ignored on byte ops
  task automatic testWriteStrobe();
    for (int op = 0; op < 10; op++) directOne("R10", op, 'hC381, 'h7F42, 1);
  endtask

  initial begin
    testLayout();
    testAdd();
    testSub();
    testCompare();
    testLogic();
    testStep("R6", 8);
    testStep("R7", 9);
    testWide();
    testUnused();
    testWriteStrobe();
    finishRun();
  end
endmodule